// File: doc/BRIEF.md
# Privileged Interrupt Pending Selector

This block decides, every cycle, whether a hart has to take an interrupt and which interrupt that is. It holds the interrupt pending register. That register is written through a masked port: bits outside the mask keep their value, and bits inside the mask take the supplied value. The active set is the pending bits that are also enabled. Each active bit belongs to one of two groups, chosen by the delegation mask. Non-delegated bits are gated by the machine-level global enable. Delegated bits are gated by the supervisor-level global enable. Both global enables depend on the current privilege level and on the matching interrupt-enable bit.

The surviving bits are merged, and the lowest-numbered one becomes the cause. The take flag and the cause are combinational from the register state and the inputs. A hard-request line tells the core whether anything at all is pending.

A second register records which pending bits a platform source has claimed. A claim is granted only when none of the requested bits is already owned. A granted claim adds the requested bits to the owned set.

Top module: `irq_pend_select`

## Requirements
- R1: An interrupt is eligible only when its bit is set in both the pending register and `enable_vec`. A pending bit whose enable is 0 is never reported.
- R2: Non-delegated bits (`deleg_mask` bit 0) are allowed when `priv_lvl` is user (2'd0) or supervisor (2'd1). They are also allowed in machine mode (2'd3) with `m_gie`=1. They are blocked in machine mode with `m_gie`=0.
- R3: Delegated bits (`deleg_mask` bit 1) are allowed in user mode, and in supervisor mode with `s_gie`=1. They are blocked in supervisor mode with `s_gie`=0, and always blocked in machine mode.
- R4: The allowed non-delegated bits and the allowed delegated bits are combined by OR. `take_irq` is 1 exactly when this combined set is non-zero.
- R5: `irq_cause` is the index of the least significant set bit of the combined set. When nothing is eligible, `take_irq`=0 and `irq_cause`=0. Both outputs follow their inputs within the same cycle.
- R6: On a clock edge with `pend_wr_en`=1, the pending register becomes (old AND NOT `pend_wr_mask`) OR (`pend_wr_val` AND `pend_wr_mask`). Without `pend_wr_en`, the register holds its value.
- R7: `hard_req` is 1 exactly when the pending register is non-zero.
- R8: `claim_ok` is 1 exactly when `claim_req`=1 and `claim_bits` shares no set bit with `claimed_q`. It is combinational.
- R9: On a clock edge with `claim_ok`=1, `claim_bits` is ORed into `claimed_q`. A refused or absent claim leaves `claimed_q` unchanged.
- R10: While `rst_n`=0, the pending register and the claimed register are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_wr_en | input | 1 | Masked write strobe for the pending register |
| pend_wr_mask | input | IRQ_W | Bits to be replaced |
| pend_wr_val | input | IRQ_W | Replacement values |
| enable_vec | input | IRQ_W | Per-interrupt enables |
| deleg_mask | input | IRQ_W | 1 = bit handled at supervisor level |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine interrupt-enable bit |
| s_gie | input | 1 | Supervisor interrupt-enable bit |
| claim_req | input | 1 | Claim attempt |
| claim_bits | input | IRQ_W | Bits the source wants to own |
| pend_q | output | IRQ_W | Pending register |
| hard_req | output | 1 | Any bit pending |
| claimed_q | output | IRQ_W | Owned bits |
| claim_ok | output | 1 | Current claim attempt is granted |
| take_irq | output | 1 | An interrupt must be taken |
| irq_cause | output | CAUSE_W | Index of the chosen interrupt |

## Verification
The assertions assume that `priv_lvl` never carries the reserved code 2'd2. They also assume that the enable, delegation and claim inputs are stable around the sampling edge. The stimulus drives privilege only from the three defined codes and changes every input at the falling edge. Random patterns reuse the same privilege set while still mixing pending, enable and delegation vectors freely. Each directed scenario moves one variable at a time, so that each gating rule is isolated.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_MACH  = 2'd3
   } lvl_e;

   localparam int LVL_W = 2;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_mask,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] pend,
   output logic         any_pend
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = pend;
      if (wr_en) nxt = (pend & ~wr_mask) | (wr_val & wr_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= nxt;
   end

   assign any_pend = |pend;
endmodule

// File: rtl/irq_claim_reg.sv
module irq_claim_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic [W-1:0] bits,
   output logic         grant,
   output logic [W-1:0] owned
);
   logic overlap;

   assign overlap = |(owned & bits);
   assign grant   = req & ~overlap;

   always_ff @(posedge clk) begin
      if (!rst_n)     owned <= '0;
      else if (grant) owned <= owned | bits;
   end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
   import irq_sel_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0]     pend,
   input  logic [W-1:0]     en,
   input  logic [W-1:0]     deleg,
   input  logic [LVL_W-1:0] lvl,
   input  logic             m_ie,
   input  logic             s_ie,
   output logic [W-1:0]     eligible
);
   logic         m_open;
   logic         s_open;
   logic [W-1:0] active;
   logic [W-1:0] m_side;
   logic [W-1:0] s_side;

   always_comb begin
      m_open = (lvl < LVL_MACH)  || ((lvl == LVL_MACH)  && m_ie);
      s_open = (lvl < LVL_SUPER) || ((lvl == LVL_SUPER) && s_ie);
   end

   assign active   = pend & en;
   assign m_side   = active & ~deleg & {W{m_open}};
   assign s_side   = active &  deleg & {W{s_open}};
   assign eligible = m_side | s_side;
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
   parameter int W         = 32,
   parameter bit SEGMENTED = 1'b1,
   parameter int GRP       = 8
) (
   input  logic [W-1:0]         vec,
   output logic                 any,
   output logic [$clog2(W)-1:0] idx
);
   localparam int IDX_W = $clog2(W);

   if (W < 2) begin : g_bad_w
      $error("irq_lsb_pick: W must be at least 2");
   end

   assign any = |vec;

   if (!SEGMENTED) begin : g_linear
      always_comb begin
         idx = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_segmented
      localparam int NG   = W / GRP;
      localparam int GI_W = $clog2(GRP);

      if ((GRP < 2) || ((W % GRP) != 0)) begin : g_bad_grp
         $error("irq_lsb_pick: GRP must be >= 2 and divide W");
      end

      logic [NG-1:0]   grp_any;
      logic [GI_W-1:0] grp_idx [NG];

      for (genvar g = 0; g < NG; g++) begin : g_grp
         logic [GRP-1:0] slice;
         assign slice      = vec[g*GRP +: GRP];
         assign grp_any[g] = |slice;
         always_comb begin
            grp_idx[g] = '0;
            for (int j = GRP - 1; j >= 0; j--) begin
               if (slice[j]) grp_idx[g] = GI_W'(j);
            end
         end
      end

      always_comb begin
         idx = '0;
         for (int g = NG - 1; g >= 0; g--) begin
            if (grp_any[g]) idx = IDX_W'(g * GRP) + IDX_W'(grp_idx[g]);
         end
      end
   end
endmodule

// File: rtl/irq_pend_select.sv
module irq_pend_select
   import irq_sel_pkg::*;
#(
   parameter int IRQ_W     = 32,
   parameter bit SEGMENTED = 1'b1,
   parameter int GRP       = 8,
   parameter int CAUSE_W   = $clog2(IRQ_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pend_wr_en,
   input  logic [IRQ_W-1:0]   pend_wr_mask,
   input  logic [IRQ_W-1:0]   pend_wr_val,
   input  logic [IRQ_W-1:0]   enable_vec,
   input  logic [IRQ_W-1:0]   deleg_mask,
   input  logic [1:0]         priv_lvl,
   input  logic               m_gie,
   input  logic               s_gie,
   input  logic               claim_req,
   input  logic [IRQ_W-1:0]   claim_bits,
   output logic [IRQ_W-1:0]   pend_q,
   output logic               hard_req,
   output logic [IRQ_W-1:0]   claimed_q,
   output logic               claim_ok,
   output logic               take_irq,
   output logic [CAUSE_W-1:0] irq_cause
);
   if ((IRQ_W < 2) || (IRQ_W > 64)) begin : g_bad_irq_w
      $error("irq_pend_select: IRQ_W out of range 2..64");
   end
   if (CAUSE_W != $clog2(IRQ_W)) begin : g_bad_cause_w
      $error("irq_pend_select: CAUSE_W must equal clog2(IRQ_W)");
   end

   logic [IRQ_W-1:0]   eligible;
   logic               pick_any;
   logic [CAUSE_W-1:0] pick_idx;

   irq_pend_reg #(.W(IRQ_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (pend_wr_en),
      .wr_mask  (pend_wr_mask),
      .wr_val   (pend_wr_val),
      .pend     (pend_q),
      .any_pend (hard_req)
   );

   irq_claim_reg #(.W(IRQ_W)) u_claim (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (claim_req),
      .bits  (claim_bits),
      .grant (claim_ok),
      .owned (claimed_q)
   );

   irq_gate #(.W(IRQ_W)) u_gate (
      .pend     (pend_q),
      .en       (enable_vec),
      .deleg    (deleg_mask),
      .lvl      (priv_lvl),
      .m_ie     (m_gie),
      .s_ie     (s_gie),
      .eligible (eligible)
   );

   irq_lsb_pick #(.W(IRQ_W), .SEGMENTED(SEGMENTED), .GRP(GRP)) u_pick (
      .vec (eligible),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign take_irq  = pick_any;
   assign irq_cause = pick_any ? pick_idx : '0;
endmodule

// File: rtl/irq_pend_select_chk.sv
module irq_pend_select_chk #(
   parameter int IRQ_W   = 32,
   parameter int CAUSE_W = $clog2(IRQ_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pend_wr_en,
   input logic [IRQ_W-1:0]   pend_wr_mask,
   input logic [IRQ_W-1:0]   pend_wr_val,
   input logic [IRQ_W-1:0]   enable_vec,
   input logic [IRQ_W-1:0]   deleg_mask,
   input logic [1:0]         priv_lvl,
   input logic               m_gie,
   input logic               s_gie,
   input logic               claim_req,
   input logic [IRQ_W-1:0]   claim_bits,
   input logic [IRQ_W-1:0]   pend_q,
   input logic               hard_req,
   input logic [IRQ_W-1:0]   claimed_q,
   input logic               claim_ok,
   input logic               take_irq,
   input logic [CAUSE_W-1:0] irq_cause
);
   a_r1_cause_active: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (pend_q[irq_cause] && enable_vec[irq_cause]));

   a_r2_mach_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && !deleg_mask[irq_cause]) |-> ((priv_lvl != 2'd3) || m_gie));

   a_r3_super_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && deleg_mask[irq_cause]) |->
         ((priv_lvl == 2'd0) || ((priv_lvl == 2'd1) && s_gie)));

   a_r5_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !take_irq |-> (irq_cause == '0));

   a_r6_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
      pend_wr_en |=> (pend_q == (($past(pend_q) & ~$past(pend_wr_mask)) |
                                 ($past(pend_wr_val) & $past(pend_wr_mask)))));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_wr_en |=> $stable(pend_q));

   a_r7_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hard_req) |-> $past(pend_wr_en));

   a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      claim_ok |-> claim_req);

   a_r9_grant_adds: assert property (@(posedge clk) disable iff (!rst_n)
      claim_ok |=> ((claimed_q & $past(claim_bits)) == $past(claim_bits)));

   a_r9_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_ok |=> $stable(claimed_q));

   a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((pend_q == '0) && (claimed_q == '0)));
endmodule

bind irq_pend_select irq_pend_select_chk #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pend_wr_en   (pend_wr_en),
   .pend_wr_mask (pend_wr_mask),
   .pend_wr_val  (pend_wr_val),
   .enable_vec   (enable_vec),
   .deleg_mask   (deleg_mask),
   .priv_lvl     (priv_lvl),
   .m_gie        (m_gie),
   .s_gie        (s_gie),
   .claim_req    (claim_req),
   .claim_bits   (claim_bits),
   .pend_q       (pend_q),
   .hard_req     (hard_req),
   .claimed_q    (claimed_q),
   .claim_ok     (claim_ok),
   .take_irq     (take_irq),
   .irq_cause    (irq_cause)
);

// File: tb/test_irq_pend_select.sv
module test_irq_pend_select;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pend_wr_en;
   logic [W-1:0]  pend_wr_mask, pend_wr_val, enable_vec, deleg_mask, claim_bits;
   logic [1:0]    priv_lvl;
   logic          m_gie, s_gie, claim_req;
   logic [W-1:0]  pend_q, claimed_q;
   logic          hard_req, claim_ok, take_irq;
   logic [4:0]    irq_cause;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_pend;
   logic [W-1:0] m_claim;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pend_select i_irq_pend_select (
      .clk(clk), .rst_n(rst_n), .pend_wr_en(pend_wr_en), .pend_wr_mask(pend_wr_mask),
      .pend_wr_val(pend_wr_val), .enable_vec(enable_vec), .deleg_mask(deleg_mask),
      .priv_lvl(priv_lvl), .m_gie(m_gie), .s_gie(s_gie), .claim_req(claim_req),
      .claim_bits(claim_bits), .pend_q(pend_q), .hard_req(hard_req),
      .claimed_q(claimed_q), .claim_ok(claim_ok), .take_irq(take_irq),
      .irq_cause(irq_cause)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference: walk bits one by one and apply the gating rules
   task automatic ref_pick(output bit t, output int c);
      bit m_on, s_on;
      m_on = (priv_lvl == 2'd0) || (priv_lvl == 2'd1) || (priv_lvl == 2'd3 && m_gie);
      s_on = (priv_lvl == 2'd0) || (priv_lvl == 2'd1 && s_gie);
      t = 0; c = 0;
      for (int i = 0; i < W; i++) begin
         if (!t && m_pend[i] && enable_vec[i] &&
             ((deleg_mask[i] && s_on) || (!deleg_mask[i] && m_on))) begin
            t = 1; c = i;
         end
      end
   endtask

   task automatic step(input string tag);
      bit t; int c; bit g;
      #1;
      ref_pick(t, c);
      g = claim_req && ((m_claim & claim_bits) == '0);
      chk({tag, " take"}, take_irq, t);
      chk({tag, " cause R5"}, irq_cause, c);
      chk("R6 pend", pend_q, m_pend);
      chk("R7 hard_req", hard_req, m_pend != '0);
      chk("R8 claim_ok", claim_ok, g);
      chk("R9 claimed", claimed_q, m_claim);
      @(posedge clk);
      if (!rst_n) begin
         m_pend = '0; m_claim = '0;
      end else begin
         if (pend_wr_en) m_pend = (m_pend & ~pend_wr_mask) | (pend_wr_val & pend_wr_mask);
         if (g) m_claim = m_claim | claim_bits;
      end
      @(negedge clk);
      pend_wr_en = 1'b0;
      claim_req  = 1'b0;
   endtask

   task automatic wr(input logic [W-1:0] m, input logic [W-1:0] v, input string tag);
      pend_wr_en = 1'b1; pend_wr_mask = m; pend_wr_val = v;
      step(tag);
   endtask

   task automatic claim(input logic [W-1:0] b, input string tag);
      claim_req = 1'b1; claim_bits = b;
      step(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] lfsr;
      rst_n = 0; pend_wr_en = 0; pend_wr_mask = '0; pend_wr_val = '0;
      enable_vec = '1; deleg_mask = '0; priv_lvl = 2'd0; m_gie = 0; s_gie = 0;
      claim_req = 0; claim_bits = '0; m_pend = '0; m_claim = '0;
      @(negedge clk);
      step("R10 reset");
      // pending write while still in reset must be discarded (R10)
      wr('1, 32'hFFFF_FFFF, "R10 reset-write");
      rst_n = 1;
      step("R10 after reset");

      wr('1, 32'h0000_0A00, "R6 full write");
      step("R2 user");                          // cause 9
      priv_lvl = 2'd3; m_gie = 0; step("R2 mach off");
      m_gie = 1;                   step("R2 mach on");
      enable_vec = 32'hFFFF_F5FF;  step("R1 disabled");
      enable_vec = 32'hFFFF_FDFF;  step("R1 partial");   // cause 11
      enable_vec = '1;
      deleg_mask = 32'h0000_0200;  step("R4 mach deleg"); // cause 11
      priv_lvl = 2'd1; s_gie = 0;  step("R4 super off");  // cause 11
      s_gie = 1;                   step("R3 super on");   // cause 9
      deleg_mask = '1; s_gie = 0;  step("R3 super all off");
      s_gie = 1;                   step("R3 super all on");
      priv_lvl = 2'd0; s_gie = 0;  step("R3 user deleg");
      priv_lvl = 2'd3; m_gie = 1;  step("R3 mach deleg");
      deleg_mask = '0;

      wr(32'h0000_0F00, 32'h0000_0100, "R6 masked");
      step("R6 after masked");
      wr('0, 32'hFFFF_FFFF, "R6 zero mask");
      step("R6 after zero mask");
      wr('1, '0, "R7 clear");
      step("R7 empty");
      wr('1, 32'h8000_0001, "R5 ends");
      step("R5 bit0");
      wr(32'h0000_0001, '0, "R5 drop0");
      step("R5 bit31");

      claim(32'h0000_0003, "R8 first");
      claim(32'h0000_0002, "R8 overlap");
      claim(32'h0000_0004, "R9 disjoint");
      claim(32'h0000_0000, "R9 empty");
      claim(32'h8000_0006, "R8 partial overlap");
      step("R9 final");

      lfsr = 32'hACE1_2345;
      for (int k = 0; k < 200; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         pend_wr_en   = lfsr[3];
         pend_wr_mask = lfsr ^ 32'h5A5A_0F0F;
         pend_wr_val  = {lfsr[15:0], lfsr[31:16]};
         enable_vec   = lfsr | 32'h1111_1111;
         deleg_mask   = ~lfsr;
         case (lfsr[5:4])
            2'd0: priv_lvl = 2'd0;
            2'd1: priv_lvl = 2'd1;
            default: priv_lvl = 2'd3;
         endcase
         m_gie = lfsr[7]; s_gie = lfsr[9];
         claim_req = lfsr[11]; claim_bits = lfsr & 32'h0000_8421;
         step("R4 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule